// File: doc/BRIEF.md
# Byte Rotate Unit with Flag Update

This block carries out the four single-bit rotate operations of an 8-bit processor's prefixed opcode page: left circular, right circular, left through carry and right through carry. A caller presents a prefixed opcode, a register operand, the current flag byte and the 16-bit HL pointer together with a one-cycle start strobe. The block returns the rotated byte and a freshly built flag byte.

When the opcode names a register, the result is ready one cycle after the strobe and the byte bus stays idle. When the opcode names the memory byte at HL, the block runs a three-cycle sequence on a simple byte bus. It reads the byte, rotates it, then writes it back to the same address. It holds busy high for the whole sequence and ignores further start strobes while it does so. Picking the destination register and the other prefixed operations are left to the surrounding datapath.

Top module: `rot_unit`

## Requirements
- R1: While reset is held and after it is released, done, busy, bus_rd and bus_wr are all low until an operation is accepted.
- R2: The opcode decodes as follows. Bits 4:3 select the kind: 0 is left circular, 1 is right circular, 2 is left through carry, 3 is right through carry. Bits 2:0 select the operand, and the value 6 selects the memory byte at HL. A strobe whose opcode has any of bits 7:5 set is ignored: it causes no done, no busy and no bus cycle.
- R3: Left circular puts old bit 7 into bit 0 and into the carry flag.
- R4: Right circular puts old bit 0 into bit 7 and into the carry flag.
- R5: Left through carry puts the incoming carry (flag bit 4) into bit 0, and old bit 7 becomes the new carry.
- R6: Right through carry puts the incoming carry into bit 7, and old bit 0 becomes the new carry.
- R7: The flag byte returned has zero at bit 7 (set exactly when the result is 0), subtract at bit 6 and half-carry at bit 5, both cleared, and carry at bit 4. Bits 3:0 are zero. Only bit 4 of the incoming flag byte has any effect.
- R8: For a register operand, done is high for exactly one cycle, starting one cycle after the strobe, with result and flags valid. Busy stays low and the bus stays idle.
- R9: For the memory operand, the first cycle after the strobe reads at HL (bus_rd). The second cycle is a compute cycle with the bus idle. The third writes the rotated byte to the same address (bus_wr). Busy is high for all three cycles, and done pulses in the cycle after the write.
- R10: A strobe arriving while busy is high is ignored.
- R11: result and flags_out keep their values after done until the next accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle operation strobe |
| opcode | input | 8 | Prefixed opcode |
| reg_operand | input | 8 | Register operand for the register form |
| flags_in | input | 8 | Current flag byte |
| hl_addr | input | 16 | Memory pointer for the memory form |
| result | output | 8 | Rotated byte |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High during a memory sequence |
| bus_addr | output | 16 | Byte bus address |
| bus_rd | output | 1 | Byte bus read cycle |
| bus_wr | output | 1 | Byte bus write cycle |
| bus_wdata | output | 8 | Byte bus write data |
| bus_rdata | input | 8 | Byte bus read data, valid in the read cycle |

## Verification
On every cycle the embedded assertions check the structure of the sequence. Read and write never overlap, and done and busy never coincide. A read is always followed by a compute cycle and then a write to the address that was read. The flag byte always has a clear low nibble, clear subtract and half-carry, and a zero bit that agrees with the result. Only the bench scenarios can show that each rotate kind moves the right bits with the right carry. They also show that invalid or overlapping strobes are dropped, and that the written byte matches the rotated memory value. The bench sweeps every byte value through every kind in both operand forms.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    ROT_LC = 2'd0,
    ROT_RC = 2'd1,
    ROT_LT = 2'd2,
    ROT_RT = 2'd3
  } rot_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CALC = 2'd2,
    ST_WR   = 2'd3
  } seq_st_e;

  localparam int FLG_Z = 7;
  localparam int FLG_N = 6;
  localparam int FLG_H = 5;
  localparam int FLG_C = 4;

endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int SEL_W   = 3,
  parameter int MEM_IDX = 6
) (
  input  logic [OP_W-1:0] opcode,
  output logic            op_valid,
  output rot_kind_e       op_kind,
  output logic            op_mem
);
  localparam int KIND_LO = SEL_W;
  localparam int HI_LO   = SEL_W + 2;

  always_comb begin
    op_valid = (opcode[OP_W-1:HI_LO] == '0);
    op_kind  = rot_kind_e'(opcode[KIND_LO+1:KIND_LO]);
    op_mem   = (opcode[SEL_W-1:0] == SEL_W'(MEM_IDX));
  end
endmodule

// File: rtl/rot_core.sv
module rot_core
  import rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  rot_kind_e         kind,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] flg
);
  localparam int MSB = DATA_W - 1;
  logic cout;

  always_comb begin
    unique case (kind)
      ROT_LC: begin res = {a[MSB-1:0], a[MSB]}; cout = a[MSB]; end
      ROT_RC: begin res = {a[0], a[MSB:1]};     cout = a[0];   end
      ROT_LT: begin res = {a[MSB-1:0], cin};    cout = a[MSB]; end
      default: begin res = {cin, a[MSB:1]};     cout = a[0];   end
    endcase
    flg        = '0;
    flg[FLG_Z] = (res == '0);
    flg[FLG_C] = cout;
  end
endmodule

// File: rtl/rot_seq.sv
module rot_seq
  import rot_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_mem,
  output seq_st_e state,
  output logic    busy
);
  seq_st_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (go_mem) state_d = ST_RD;
      ST_RD:   state_d = ST_CALC;
      ST_CALC: state_d = ST_WR;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  assign busy = (state != ST_IDLE);

  // R9: read is always followed by compute, compute by write
  assert_rd_then_calc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RD |=> state == ST_CALC);
  assert_calc_then_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CALC |=> state == ST_WR);
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int OP_W    = 8,
  parameter int SEL_W   = 3,
  parameter int MEM_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] reg_operand,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [ADDR_W-1:0] hl_addr,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flags_out,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic      op_valid, op_mem;
  rot_kind_e op_kind;
  rot_decode #(.OP_W(OP_W), .SEL_W(SEL_W), .MEM_IDX(MEM_IDX)) u_dec (
    .opcode(opcode), .op_valid(op_valid), .op_kind(op_kind), .op_mem(op_mem)
  );

  logic    accept, go_mem, go_reg;
  seq_st_e state;
  rot_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .go_mem(go_mem), .state(state), .busy(busy)
  );

  assign accept = start & op_valid & ~busy;
  assign go_mem = accept & op_mem;
  assign go_reg = accept & ~op_mem;

  // captured context for the memory form
  rot_kind_e         kind_q, kind_d;
  logic              cin_q, cin_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;
  logic              ctx_en, opnd_en;

  assign ctx_en  = go_mem;
  assign opnd_en = (state == ST_RD);

  always_comb begin
    kind_d = ctx_en  ? op_kind          : kind_q;
    cin_d  = ctx_en  ? flags_in[FLG_C]  : cin_q;
    addr_d = ctx_en  ? hl_addr          : addr_q;
    opnd_d = opnd_en ? bus_rdata        : opnd_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      kind_q <= ROT_LC;
      cin_q  <= 1'b0;
      addr_q <= '0;
      opnd_q <= '0;
    end else begin
      kind_q <= kind_d;
      cin_q  <= cin_d;
      addr_q <= addr_d;
      opnd_q <= opnd_d;
    end
  end

  // shared rotate datapath
  logic              calc;
  logic [DATA_W-1:0] core_a, core_res, core_flg;
  rot_kind_e         core_kind;
  logic              core_cin;

  assign calc = (state == ST_CALC);
  always_comb begin
    core_a    = calc ? opnd_q : reg_operand;
    core_kind = calc ? kind_q : op_kind;
    core_cin  = calc ? cin_q  : flags_in[FLG_C];
  end

  rot_core #(.DATA_W(DATA_W)) u_core (
    .a(core_a), .kind(core_kind), .cin(core_cin), .res(core_res), .flg(core_flg)
  );

  // output registers
  logic [DATA_W-1:0] res_q, res_d, flg_q, flg_d;
  logic              done_q, done_d, out_en;

  assign out_en = go_reg | calc;
  always_comb begin
    res_d  = out_en ? core_res : res_q;
    flg_d  = out_en ? core_flg : flg_q;
    done_d = go_reg | (state == ST_WR);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  assign result    = res_q;
  assign flags_out = flg_q;
  assign done      = done_q;
  assign bus_addr  = addr_q;
  assign bus_rd    = (state == ST_RD);
  assign bus_wr    = (state == ST_WR);
  assign bus_wdata = res_q;

  // R9: read and write cycles never overlap
  assert_bus_excl_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(bus_rd && bus_wr));
  // R8: completion is never reported while a sequence is running
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(done && busy));
  // R9: write-back goes to the address that was read two cycles earlier
  assert_wr_same_addr_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_wr |-> (bus_addr == $past(bus_addr, 2)) && $past(bus_rd, 2));
  // R7: flag byte shape on completion
  assert_flag_shape_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (flags_out[3:0] == 4'h0) && !flags_out[FLG_N] && !flags_out[FLG_H]
             && (flags_out[FLG_Z] == (result == '0)));
  // R11: outputs hold while nothing is being computed
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!$past(go_reg) && !$past(calc)) |-> $stable(result) && $stable(flags_out));
  // R10: a strobe during busy does not produce an early completion
  assert_no_done_mid_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state == ST_RD || state == ST_CALC) |=> !done);
endmodule

// File: tb/tb_rot_unit.sv
module tb_rot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  reg_operand = 8'h00;
  logic [7:0]  flags_in = 8'h00;
  logic [15:0] hl_addr = 16'h0000;
  logic [7:0]  result, flags_out, bus_wdata, bus_rdata;
  logic        done, busy, bus_rd, bus_wr;
  logic [15:0] bus_addr;

  logic [7:0]  mem_byte = 8'h00;
  logic [7:0]  wr_seen;
  logic [15:0] wr_addr_seen;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rot_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .reg_operand(reg_operand), .flags_in(flags_in), .hl_addr(hl_addr),
    .result(result), .flags_out(flags_out), .done(done), .busy(busy),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign bus_rdata = (bus_addr == hl_addr) ? mem_byte : 8'hA5;
  always @(posedge clk) if (bus_wr) begin
    wr_seen      <= bus_wdata;
    wr_addr_seen <= bus_addr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // returns {flags, result}
  function automatic logic [15:0] model(input logic [1:0] k, input logic [7:0] a, input logic c);
    logic [7:0] r; logic co;
    case (k)
      2'd0: begin r = {a[6:0], a[7]}; co = a[7]; end
      2'd1: begin r = {a[0], a[7:1]}; co = a[0]; end
      2'd2: begin r = {a[6:0], c};    co = a[7]; end
      default: begin r = {c, a[7:1]}; co = a[0]; end
    endcase
    return {(r == 8'h00), 2'b00, co, 4'h0, r};
  endfunction

  function automatic string ktag(input logic [1:0] k);
    case (k)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic reg_op(input logic [1:0] k, input logic [7:0] a, input logic c, input logic [2:0] sel);
    logic [15:0] e;
    e = model(k, a, c);
    @(negedge clk);
    start = 1'b1; opcode = {3'b000, k, sel}; reg_operand = a;
    flags_in = {~a[7:5], c, a[3:0]};
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0 && !bus_rd && !bus_wr, "R8", {done, busy}, 2'b10);
    chk(result == e[7:0], ktag(k), result, e[7:0]);
    chk(flags_out == e[15:8], "R7", flags_out, e[15:8]);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    chk(result == e[7:0] && flags_out == e[15:8], "R11", result, e[7:0]);
  endtask

  task automatic mem_op(input logic [1:0] k, input logic [7:0] a, input logic c,
                        input logic [15:0] hl, input bit poke);
    logic [15:0] e;
    e = model(k, a, c);
    @(negedge clk);
    mem_byte = a; hl_addr = hl;
    start = 1'b1; opcode = {3'b000, k, 3'd6}; flags_in = {3'b111, c, 4'hF};
    @(negedge clk);
    start = 1'b0;
    chk(bus_rd && !bus_wr && busy && bus_addr == hl, "R9", {bus_rd, bus_wr, busy}, 3'b101);
    if (poke) begin
      start = 1'b1; opcode = 8'h00; reg_operand = 8'h80;
      flags_in = {3'b000, ~c, 4'h0};
    end
    @(negedge clk);
    start = 1'b0;
    chk(!bus_rd && !bus_wr && busy && !done, poke ? "R10" : "R9", {bus_rd, bus_wr, busy, done}, 4'b0010);
    @(negedge clk);
    chk(bus_wr && !bus_rd && busy && bus_addr == hl, "R9", {bus_rd, bus_wr, busy}, 3'b011);
    chk(bus_wdata == e[7:0], ktag(k), bus_wdata, e[7:0]);
    @(negedge clk);
    chk(done && !busy && !bus_rd && !bus_wr, "R9", {done, busy}, 2'b10);
    chk(wr_seen == e[7:0] && wr_addr_seen == hl, "R9", wr_seen, e[7:0]);
    chk(result == e[7:0], ktag(k), result, e[7:0]);
    chk(flags_out == e[15:8], "R7", flags_out, e[15:8]);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !busy && !bus_rd && !bus_wr, "R1", {done, busy, bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !busy && !bus_rd && !bus_wr, "R1", {done, busy, bus_rd, bus_wr}, 0);

    // R2: opcodes above the rotate group are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      start = 1'b1; opcode = 8'h20 + 8'(i * 29); reg_operand = 8'h81;
      @(negedge clk);
      start = 1'b0;
      chk(!done && !busy && !bus_rd, "R2", {done, busy}, 0);
      @(negedge clk);
      chk(!done && !busy && !bus_rd, "R2", {done, busy}, 0);
    end

    // R3..R8: register form, exhaustive over value, kind and carry
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 2; c++)
          reg_op(2'(k), 8'(v), c[0], (v[2:0] == 3'd6) ? 3'd7 : v[2:0]);

    // R9, R10: memory form, exhaustive over value and kind
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 256; v++)
        mem_op(2'(k), 8'(v), v[3] ^ k[0], {8'(v), ~8'(v)}, (v % 5) == 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule